// File: doc/BRIEF.md
# ECC Generate and Check Bridge for a Bus Master

This block sits between a bus master that produces and consumes plain data, such as a DMA read/write port, and an interconnect whose targets hold data together with SECDED check bits. On the write side it computes eight check bits from each 64-bit write word. It then places the word, its address and its check bits into one output register, so that all three leave together under a valid/ready handshake. On the read side the request is passed straight through. The block remembers the address of every outstanding read, in order. Each returned word is decoded against its check bits: a single flipped bit is repaired, and a double error is passed through untouched. The result reaches the master one cycle later.

Decode results are reported on two one-cycle pulse outputs, correctable and uncorrectable, each with the address of the read that caused it. These outputs feed an error-profiling unit, not a system error collector. Reporting is off by default. It turns on only while a 4-bit unlock field, written through a small configuration port, holds the value 0xA. Each instance of the bridge has its own unlock field.

Top module: `ecc_master_bridge`

## Requirements
- R1: For each write, s_w_chk is computed from the data as follows. The codeword has positions 1 to 71, and the seven power-of-two positions are left free. Data bit j takes the (j+1)-th remaining position in ascending order. chk[i] for i in 0..6 is the XOR of every data bit whose position has bit i set. chk[7] is the XOR of all 64 data bits and chk[6:0].
- R2: While s_w_valid is high and s_w_ready is low, s_w_valid, s_w_addr, s_w_data and s_w_chk hold their values.
- R3: A write accepted at a clock edge appears on s_w_* from the next cycle. m_w_ready is low only while the output register is full and s_w_ready is low.
- R4: When the returned 72-bit codeword has exactly one bit flipped, in data or in check bits, m_r_data carries the original data. err_cor pulses if reporting is enabled.
- R5: When exactly two bits of the codeword are flipped, m_r_data equals the received data unmodified. err_unc pulses if reporting is enabled.
- R6: A clean codeword is delivered unchanged, and neither error output pulses.
- R7: err_cor and err_unc are registered pulses. They are high only in the cycle in which m_r_valid first presents the response that caused them, never both at once. err_addr then holds the address of the matching read request, with responses matched to requests in issue order.
- R8: The 4-bit unlock field is written when cfg_key_we is high and resets to 0. Error pulses are produced only while it holds 0xA. Correction of the data does not depend on it.
- R9: A response accepted from the slave appears on m_r_* in the next cycle. m_r_valid and m_r_data stay stable while m_r_ready is low.
- R10: A read request is passed on in the same cycle (s_ar_valid and s_ar_addr follow m_ar_*). While RD_OUTSTANDING reads are pending without a response, both m_ar_ready and s_ar_valid are held low.
- R11: After reset, m_r_valid, s_w_valid, err_cor and err_unc are low, and m_w_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_key_we | input | 1 | Write strobe for the unlock field |
| cfg_key | input | 4 | Unlock field value |
| m_ar_valid | input | 1 | Master read request valid |
| m_ar_ready | output | 1 | Read request accepted |
| m_ar_addr | input | ADDR_W | Master read address |
| m_w_valid | input | 1 | Master write valid |
| m_w_ready | output | 1 | Write accepted |
| m_w_addr | input | ADDR_W | Write address |
| m_w_data | input | DATA_W | Write data |
| m_r_valid | output | 1 | Read data valid toward master |
| m_r_ready | input | 1 | Master accepts read data |
| m_r_data | output | DATA_W | Checked and corrected read data |
| s_ar_valid | output | 1 | Read request toward slave |
| s_ar_ready | input | 1 | Slave accepts read request |
| s_ar_addr | output | ADDR_W | Read address toward slave |
| s_w_valid | output | 1 | Write toward slave valid |
| s_w_ready | input | 1 | Slave accepts write |
| s_w_addr | output | ADDR_W | Write address toward slave |
| s_w_data | output | DATA_W | Write data toward slave |
| s_w_chk | output | CHK_W | Check bits for s_w_data |
| s_r_valid | input | 1 | Read response valid from slave |
| s_r_ready | output | 1 | Bridge accepts read response |
| s_r_data | input | DATA_W | Returned data |
| s_r_chk | input | CHK_W | Returned check bits |
| err_cor | output | 1 | Correctable error pulse |
| err_unc | output | 1 | Uncorrectable error pulse |
| err_addr | output | ADDR_W | Address of the read behind the pulse |

## Verification
The bench flips every one of the 72 codeword bits in turn on several data words, and applies 72 distinct bit pairs to each word. A decoder with a wrong syndrome mapping would damage a data bit that was correct. One that confused double and single errors would "repair" a double error into a third wrong bit, or raise the wrong pulse. Flips of check bits alone, including the overall parity bit, must leave the data untouched. Some reads are made with the unlock field at 0, 0x5 and 0xB: a design that decoded the key loosely would report errors while locked. The bench also fills the outstanding-read window and then drains it back to back. A wrong address queue would tag pulses with the wrong or a stale address, or let a fifth request through. Both channels are stalled so that a register that lost its held value is caught.

// File: rtl/ecc_bridge_pkg.sv
package ecc_bridge_pkg;

   // Smallest parity count p with 2**p >= data + p + 1 (Hamming bound).
   function automatic int unsigned calc_par_bits(input int unsigned dw);
      int unsigned p;
      p = 0;
      for (int unsigned q = 2; q < 31; q++) begin
         if (p == 0 && (32'd1 << q) >= dw + q + 1) p = q;
      end
      return p;
   endfunction

   // Codeword position (1-based) that data bit j occupies: the (j+1)-th
   // position that is not a power of two.
   function automatic int unsigned data_pos(input int unsigned j);
      int unsigned pos;
      int unsigned cnt;
      bit          found;
      pos   = 0;
      cnt   = 0;
      found = 1'b0;
      for (int unsigned p = 1; p <= j + 40; p++) begin
         if (!found && ((p & (p - 1)) != 0)) begin
            if (cnt == j) begin
               pos   = p;
               found = 1'b1;
            end
            cnt++;
         end
      end
      return pos;
   endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned PAR_W = ecc_bridge_pkg::calc_par_bits(DATA_W),
   localparam int unsigned CHK_W = PAR_W + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   function automatic logic [DATA_W-1:0] cover_mask(input int unsigned sel);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int unsigned j = 0; j < DATA_W; j++) begin
         if (((ecc_bridge_pkg::data_pos(j) >> sel) & 32'd1) != 0) m[j] = 1'b1;
      end
      return m;
   endfunction

   for (genvar i = 0; i < PAR_W; i++) begin : g_par
      localparam logic [DATA_W-1:0] MASK = cover_mask(i);
      assign chk[i] = ^(data & MASK);
   end

   // Overall parity over data and the Hamming bits gives double-error detection.
   assign chk[PAR_W] = (^data) ^ (^chk[PAR_W-1:0]);

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned PAR_W  = ecc_bridge_pkg::calc_par_bits(DATA_W),
   localparam int unsigned CHK_W  = PAR_W + 1,
   localparam int unsigned MAXPOS = DATA_W + PAR_W
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [CHK_W-1:0]  chk_in,
   output logic [DATA_W-1:0] data_out,
   output logic              cor,
   output logic              unc
);

   logic [CHK_W-1:0] recalc;
   logic [PAR_W-1:0] syn;
   logic             odd;
   logic             in_range;

   ecc_secded_enc #(.DATA_W(DATA_W)) u_recalc (
      .data (data_in),
      .chk  (recalc)
   );

   assign syn      = recalc[PAR_W-1:0] ^ chk_in[PAR_W-1:0];
   assign odd      = (^data_in) ^ (^chk_in);
   assign in_range = 32'(syn) <= MAXPOS;
   // Odd overall parity: one flip (possibly in a check bit). Even parity with a
   // nonzero syndrome, or an impossible position: two or more flips.
   assign cor      = odd && in_range;
   assign unc      = (!odd && syn != '0) || (odd && !in_range);

   for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam int unsigned POS = ecc_bridge_pkg::data_pos(j);
      assign data_out[j] = data_in[j] ^ (cor && (syn == PAR_W'(POS)));
   end

   always_comb begin
      assert_decode_excl_R7: assert (!(cor && unc) || $isunknown({cor, unc}));
   end

endmodule

// File: rtl/ecc_pipe_reg.sv
module ecc_pipe_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);

   logic             vld_q;
   logic [WIDTH-1:0] dat_q;

   assign in_ready  = !vld_q || out_ready;
   assign out_valid = vld_q;
   assign out_data  = dat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (in_ready) begin
         vld_q <= in_valid;
         if (in_valid) dat_q <= in_data;
      end
   end

   // Output holds under backpressure (R2 on the write side).
   assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/ecc_addr_fifo.sv
module ecc_addr_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
   endfunction

   assign full  = 32'(cnt_q) == DEPTH;
   assign empty = cnt_q == '0;
   assign head  = mem[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= bump(wr_q);
         if (pop)  rd_q <= bump(rd_q);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_data;
   end

   assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/ecc_master_bridge.sv
module ecc_master_bridge #(
   parameter int unsigned DATA_W         = 64,
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned RD_OUTSTANDING = 4,
   parameter int unsigned KEY_W          = 4,
   parameter logic [KEY_W-1:0] UNLOCK    = 4'hA,
   localparam int unsigned CHK_W = ecc_bridge_pkg::calc_par_bits(DATA_W) + 1,
   localparam int unsigned WR_W  = ADDR_W + DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_key_we,
   input  logic [KEY_W-1:0]  cfg_key,
   input  logic              m_ar_valid,
   output logic              m_ar_ready,
   input  logic [ADDR_W-1:0] m_ar_addr,
   input  logic              m_w_valid,
   output logic              m_w_ready,
   input  logic [ADDR_W-1:0] m_w_addr,
   input  logic [DATA_W-1:0] m_w_data,
   output logic              m_r_valid,
   input  logic              m_r_ready,
   output logic [DATA_W-1:0] m_r_data,
   output logic              s_ar_valid,
   input  logic              s_ar_ready,
   output logic [ADDR_W-1:0] s_ar_addr,
   output logic              s_w_valid,
   input  logic              s_w_ready,
   output logic [ADDR_W-1:0] s_w_addr,
   output logic [DATA_W-1:0] s_w_data,
   output logic [CHK_W-1:0]  s_w_chk,
   input  logic              s_r_valid,
   output logic              s_r_ready,
   input  logic [DATA_W-1:0] s_r_data,
   input  logic [CHK_W-1:0]  s_r_chk,
   output logic              err_cor,
   output logic              err_unc,
   output logic [ADDR_W-1:0] err_addr
);

   if (DATA_W < 4)          begin : g_bad_dw  $error("DATA_W must be at least 4");  end
   if (ADDR_W < 1)          begin : g_bad_aw  $error("ADDR_W must be at least 1");  end
   if (RD_OUTSTANDING < 1)  begin : g_bad_dep $error("RD_OUTSTANDING must be >= 1"); end

   // ---------------- unlock field ----------------
   logic [KEY_W-1:0] key_q;
   logic             report_on;

   always_ff @(posedge clk) begin
      if (!rst_n)          key_q <= '0;
      else if (cfg_key_we) key_q <= cfg_key;
   end
   assign report_on = key_q == UNLOCK;

   // ---------------- write path ----------------
   logic [CHK_W-1:0] w_chk;
   logic [WR_W-1:0]  w_out;

   ecc_secded_enc #(.DATA_W(DATA_W)) u_wenc (
      .data (m_w_data),
      .chk  (w_chk)
   );

   ecc_pipe_reg #(.WIDTH(WR_W)) u_wpipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (m_w_valid),
      .in_ready  (m_w_ready),
      .in_data   ({m_w_addr, m_w_data, w_chk}),
      .out_valid (s_w_valid),
      .out_ready (s_w_ready),
      .out_data  (w_out)
   );
   assign {s_w_addr, s_w_data, s_w_chk} = w_out;

   // ---------------- read request and address tracking ----------------
   logic              q_full, q_empty, rd_fire;
   logic [ADDR_W-1:0] q_head;

   assign s_ar_valid = m_ar_valid && !q_full;
   assign s_ar_addr  = m_ar_addr;
   assign m_ar_ready = s_ar_ready && !q_full;

   ecc_addr_fifo #(.WIDTH(ADDR_W), .DEPTH(RD_OUTSTANDING)) u_aq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (m_ar_valid && m_ar_ready),
      .push_data (m_ar_addr),
      .pop       (rd_fire),
      .head      (q_head),
      .full      (q_full),
      .empty     (q_empty)
   );

   // ---------------- read response path ----------------
   logic [DATA_W-1:0] r_fixed;
   logic              d_cor, d_unc;

   ecc_secded_dec #(.DATA_W(DATA_W)) u_rdec (
      .data_in  (s_r_data),
      .chk_in   (s_r_chk),
      .data_out (r_fixed),
      .cor      (d_cor),
      .unc      (d_unc)
   );

   ecc_pipe_reg #(.WIDTH(DATA_W)) u_rpipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s_r_valid),
      .in_ready  (s_r_ready),
      .in_data   (r_fixed),
      .out_valid (m_r_valid),
      .out_ready (m_r_ready),
      .out_data  (m_r_data)
   );

   assign rd_fire = s_r_valid && s_r_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_cor  <= 1'b0;
         err_unc  <= 1'b0;
         err_addr <= '0;
      end else begin
         err_cor <= rd_fire && d_cor && report_on;
         err_unc <= rd_fire && d_unc && report_on;
         if (rd_fire) err_addr <= q_head;
      end
   end

   assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_cor && err_unc));
   assert_err_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cor || err_unc) |-> m_r_valid);
   assert_err_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cor || err_unc) |-> ($past(key_q) == UNLOCK));
   assert_rsp_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s_r_valid |-> !q_empty);
   assert_ar_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> (!m_ar_ready && !s_ar_valid));

endmodule

// File: tb/ecc_master_bridge_tb.sv
module ecc_master_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_key_we = 1'b0;
   logic [3:0]  cfg_key = '0;
   logic        m_ar_valid = 1'b0, m_ar_ready;
   logic [31:0] m_ar_addr = '0;
   logic        m_w_valid = 1'b0, m_w_ready;
   logic [31:0] m_w_addr = '0;
   logic [63:0] m_w_data = '0;
   logic        m_r_valid, m_r_ready = 1'b0;
   logic [63:0] m_r_data;
   logic        s_ar_valid, s_ar_ready = 1'b1;
   logic [31:0] s_ar_addr;
   logic        s_w_valid, s_w_ready = 1'b0;
   logic [31:0] s_w_addr;
   logic [63:0] s_w_data;
   logic [7:0]  s_w_chk;
   logic        s_r_valid = 1'b0, s_r_ready;
   logic [63:0] s_r_data = '0;
   logic [7:0]  s_r_chk = '0;
   logic        err_cor, err_unc;
   logic [31:0] err_addr;

   int vectors = 0;
   int fails   = 0;

   always #2.5 clk = ~clk;

   ecc_master_bridge u_dut (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Independent codeword construction (R1).
   function automatic logic [7:0] ref_chk(input logic [63:0] d);
      logic [127:0] cw;
      logic [7:0]   c;
      int           j;
      cw = '0;
      j  = 0;
      for (int p = 1; p <= 71; p++) begin
         if ((p & (p - 1)) != 0) begin
            cw[p] = d[j];
            j++;
         end
      end
      c = '0;
      for (int i = 0; i < 7; i++)
         for (int p = 1; p <= 71; p++)
            if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
      c[7] = (^d) ^ (^c[6:0]);
      return c;
   endfunction

   task automatic set_key(input logic [3:0] k);
      @(negedge clk);
      cfg_key_we = 1'b1;
      cfg_key    = k;
      @(negedge clk);
      cfg_key_we = 1'b0;
   endtask

   task automatic do_write(input logic [31:0] a, input logic [63:0] d);
      logic [7:0] ec;
      ec = ref_chk(d);
      @(negedge clk);
      m_w_valid = 1'b1; m_w_addr = a; m_w_data = d; s_w_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      m_w_valid = 1'b0;
      check(s_w_valid === 1'b1, "R3", "s_w_valid next cycle", 64'(s_w_valid), 64'd1);
      check(s_w_chk === ec, "R1", "check bits", 64'(s_w_chk), 64'(ec));
      check(s_w_data === d && s_w_addr === a, "R3", "write data/addr", s_w_data, d);
      check(m_w_ready === 1'b0, "R3", "m_w_ready while full and stalled", 64'(m_w_ready), 64'd0);
      @(posedge clk);
      @(negedge clk);
      check(s_w_valid === 1'b1 && s_w_data === d && s_w_chk === ec && s_w_addr === a,
            "R2", "hold under backpressure", s_w_data, d);
      s_w_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(s_w_valid === 1'b0 && m_w_ready === 1'b1, "R3", "drained", 64'(s_w_valid), 64'd0);
      s_w_ready = 1'b0;
   endtask

   task automatic do_read(input logic [31:0] a, input logic [63:0] d, input logic [7:0] c,
                          input logic [63:0] exp_d, input bit exp_cor, input bit exp_unc,
                          input string req);
      @(negedge clk);
      m_ar_valid = 1'b1; m_ar_addr = a;
      #0.1;
      check(s_ar_valid === 1'b1 && s_ar_addr === a, "R10", "request forwarded", 64'(s_ar_addr), 64'(a));
      @(posedge clk);
      @(negedge clk);
      m_ar_valid = 1'b0;
      s_r_valid = 1'b1; s_r_data = d; s_r_chk = c; m_r_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      s_r_valid = 1'b0;
      check(m_r_valid === 1'b1, "R9", "m_r_valid one cycle later", 64'(m_r_valid), 64'd1);
      check(m_r_data === exp_d, req, "read data", m_r_data, exp_d);
      check(err_cor === exp_cor, req, "err_cor", 64'(err_cor), 64'(exp_cor));
      check(err_unc === exp_unc, req, "err_unc", 64'(err_unc), 64'(exp_unc));
      if (exp_cor || exp_unc)
         check(err_addr === a, "R7", "err_addr", 64'(err_addr), 64'(a));
      @(posedge clk);
      @(negedge clk);
      check(err_cor === 1'b0 && err_unc === 1'b0, "R7", "pulse one cycle", 64'({err_cor, err_unc}), 64'd0);
      check(m_r_valid === 1'b1 && m_r_data === exp_d, "R9", "hold under backpressure", m_r_data, exp_d);
      m_r_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      m_r_ready = 1'b0;
      check(m_r_valid === 1'b0, "R9", "response consumed", 64'(m_r_valid), 64'd0);
   endtask

   function automatic logic [71:0] flip(input logic [71:0] cw, input int k);
      logic [71:0] r;
      r = cw;
      r[k] = ~r[k];
      return r;
   endfunction

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : main
      logic [63:0] pats [4];
      logic [71:0] cw, bad;
      logic [31:0] qa [4];
      pats[0] = 64'h0;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'hA5A5_5A5A_3C3C_C3C3;
      pats[3] = 64'h0123_4567_89AB_CDEF;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #0.1;
      check(m_r_valid === 1'b0 && s_w_valid === 1'b0, "R11", "valids after reset",
            64'({m_r_valid, s_w_valid}), 64'd0);
      check(err_cor === 1'b0 && err_unc === 1'b0, "R11", "errors after reset",
            64'({err_cor, err_unc}), 64'd0);
      check(m_w_ready === 1'b1, "R11", "m_w_ready after reset", 64'(m_w_ready), 64'd1);

      // Writes: walking ones plus patterns (R1, R2, R3)
      for (int b = 0; b < 64; b++) do_write(32'h1000 + 32'(b * 8), 64'd1 << b);
      for (int p = 0; p < 4; p++) do_write(32'h2000 + 32'(p), pats[p]);

      // Locked at reset value 0 (R8): correction yes, pulses no
      cw  = {ref_chk(pats[2]), pats[2]};
      bad = flip(cw, 5);
      do_read(32'h30, bad[63:0], bad[71:64], pats[2], 1'b0, 1'b0, "R8");

      set_key(4'hA);
      for (int p = 0; p < 4; p++) begin
         cw = {ref_chk(pats[p]), pats[p]};
         do_read(32'h4000 + 32'(p), cw[63:0], cw[71:64], pats[p], 1'b0, 1'b0, "R6");
         for (int k = 0; k < 72; k++) begin
            bad = flip(cw, k);
            do_read(32'h5000 + 32'(p * 128 + k), bad[63:0], bad[71:64], pats[p], 1'b1, 1'b0, "R4");
         end
         for (int k = 0; k < 72; k++) begin
            bad = flip(flip(cw, k), (k + 5) % 72);
            do_read(32'h6000 + 32'(p * 128 + k), bad[63:0], bad[71:64], bad[63:0], 1'b0, 1'b1, "R5");
         end
      end

      // Wrong keys lock reporting again (R8)
      set_key(4'h5);
      cw  = {ref_chk(pats[3]), pats[3]};
      bad = flip(cw, 17);
      do_read(32'h70, bad[63:0], bad[71:64], pats[3], 1'b0, 1'b0, "R8");
      set_key(4'hB);
      bad = flip(flip(cw, 1), 40);
      do_read(32'h74, bad[63:0], bad[71:64], bad[63:0], 1'b0, 1'b0, "R8");
      set_key(4'hA);

      // Outstanding limit and in-order address matching (R10, R7)
      for (int i = 0; i < 4; i++) begin
         qa[i] = 32'hC000 + 32'(i * 4);
         @(negedge clk);
         m_ar_valid = 1'b1; m_ar_addr = qa[i];
         @(posedge clk);
      end
      @(negedge clk);
      m_ar_addr = 32'hDEAD;
      #0.1;
      check(m_ar_ready === 1'b0 && s_ar_valid === 1'b0, "R10", "window full blocks",
            64'({m_ar_ready, s_ar_valid}), 64'd0);
      m_ar_valid = 1'b0;
      m_r_ready  = 1'b1;
      for (int i = 0; i < 4; i++) begin
         cw  = {ref_chk(pats[i]), pats[i]};
         bad = flip(cw, 10 + i);
         s_r_valid = 1'b1; s_r_data = bad[63:0]; s_r_chk = bad[71:64];
         @(posedge clk);
         @(negedge clk);
         check(err_cor === 1'b1 && err_addr === qa[i], "R7", "in-order err_addr",
               64'(err_addr), 64'(qa[i]));
         check(m_r_data === pats[i], "R4", "back-to-back correction", m_r_data, pats[i]);
         if (i == 0)
            check(m_ar_ready === 1'b1, "R10", "window reopens", 64'(m_ar_ready), 64'd1);
      end
      s_r_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      m_r_ready = 1'b0;
      check(m_r_valid === 1'b0 && err_cor === 1'b0, "R7", "drain complete",
            64'({m_r_valid, err_cor}), 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule